// File: doc/BRIEF.md
# UART Receive Status Tracker

This block keeps the receive-side status word of a UART. It sits between a character deserializer, a receive FIFO and the register bank that software reads. It does not store data. It watches per-character completion strobes with their error indications, the FIFO level signals, software reads of the data register and writes to the status register. From these it builds one 32-bit status word.

Error flags (break, parity, framing) have two behaviours, chosen by a mode input:

- **Programmed-I/O mode:** each data-register read loads the flags with the errors of the character just read.
- **DMA mode:** a receive command is opened by a start pulse and closed by an end pulse. The flags collect the errors of every character accepted while the command is open.

The overrun flag records a character that arrived while the FIFO was full; that character is dropped and the FIFO contents are untouched. A byte counter tallies the characters accepted during a DMA command. A four-bit invalid-lane mask describes the last data word read.

Top module: `uart_rx_status`

## Requirements

Status word bit positions (default parameters):

| Bits | Content |
|------|---------|
| 15:0 | DMA byte count |
| 19:16 | Invalid-lane mask (bit 16 = lane 0) |
| 20 | Framing flag |
| 21 | Parity flag |
| 22 | Break flag |
| 23 | Overrun flag |
| 24 | Receive FIFO empty |
| 25 | Receive FIFO full |
| 26 | Transmit FIFO full |
| 31:27 | Zero |

The error inputs `charErr` and `readErr` are ordered {break, parity, framing}.

- R1: Bits 24, 25 and 26 follow `rxFifoEmpty`, `rxFifoFull` and `txFifoFull` combinationally, with no clock delay. Bits 31:27 always read zero.
- R2: The overrun flag (bit 23) sets in the cycle after `charDone` is high while `rxFifoFull` is high. Such a character is neither counted nor folded into the error flags. A set and a status write in the same cycle leave the flag set.
- R3: Any `statWrite` clears the overrun flag on the next cycle, whatever the data written.
- R4: In programmed-I/O mode (`dmaMode`=0), a `dataRead` loads bits 22:20 with `readErr` on the next cycle.
- R5: In DMA mode, a `dmaStart` pulse clears bits 22:20. After that, each of these flags becomes set once any accepted character carries that error, and stays set. A `dataRead` in DMA mode leaves them unchanged.
- R6: A `statWrite` with a 0 in bit 20, 21 or 22 of `statWrData` clears that flag; a 1 there leaves it alone. A load or an accumulation in the same cycle takes precedence over the clear.
- R7: A character is accepted when `charDone` is high, `rxFifoFull` is low, `dmaMode` is high and a DMA command is open. A command is open in its start cycle, through its end-pulse cycle, and not after that. `dmaStart` zeroes the byte count. Each accepted character adds one, including one in the start cycle. The count holds after the command ends.
- R8: The byte count saturates at 0xFFFF.
- R9: On `dataRead`, lane i of bits 19:16 becomes 1 when i is not less than `readBytes` (values above 4 count as 4). A full four-byte read therefore gives 0000, and a zero-byte read gives 1111.
- R10: While reset is asserted, and right after it, every flag, the mask and the count are zero.

## Ports

| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dmaMode | input | 1 | 1 = DMA error behaviour, 0 = programmed-I/O |
| charDone | input | 1 | A character has left the deserializer |
| charErr | input | 3 | Errors of that character {break, parity, framing} |
| rxFifoFull | input | 1 | Receive FIFO full level |
| rxFifoEmpty | input | 1 | Receive FIFO empty level |
| txFifoFull | input | 1 | Transmit FIFO full level |
| dataRead | input | 1 | Software read of the receive data register |
| readErr | input | 3 | Errors of the character read {break, parity, framing} |
| readBytes | input | 3 | Valid bytes in the word read (0 to 4) |
| dmaStart | input | 1 | DMA receive command start pulse |
| dmaEnd | input | 1 | DMA receive command end pulse |
| statWrite | input | 1 | Write strobe of the status register |
| statWrData | input | 32 | Data written to the status register |
| status | output | 32 | Packed status word |

## Verification

The properties assume that `charErr` matters only while `charDone` is high. They also assume that `readBytes` stays within 0 to 4 whenever `dataRead` is high, and that the start and end pulses each last one cycle. The stimulus table keeps to these rules. It also drives the same-cycle collisions on purpose: set against write, start against character, accumulation against clear. This means the precedence properties are exercised, not just left unviolated.

// File: rtl/uart_rx_status_pkg.sv
package uart_rx_status_pkg;
  localparam int NUM_ERR = 3;   // index 0 framing, 1 parity, 2 break

  typedef struct packed {
    logic                setOvr;
    logic                clrOvr;
    logic                loadPio;
    logic                accDma;
    logic [NUM_ERR-1:0]  clrErr;
    logic                dmaClr;
    logic                cntInc;
    logic                loadInv;
  } rxStrobes_t;
endpackage

// File: rtl/uart_rx_status_ctrl.sv
module uart_rx_status_ctrl
  import uart_rx_status_pkg::*;
#(
  parameter int ERR_LSB = 20,
  parameter int STAT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dmaMode,
  input  logic              charDone,
  input  logic              rxFifoFull,
  input  logic              dataRead,
  input  logic              dmaStart,
  input  logic              dmaEnd,
  input  logic              statWrite,
  input  logic [STAT_W-1:0] statWrData,
  output rxStrobes_t        strobes
);
  logic dmaActive;
  logic accepted;

  always_ff @(posedge clk) begin
    if (!rstN) dmaActive <= 1'b0;
    else       dmaActive <= dmaStart | (dmaActive & ~dmaEnd);
  end

  assign accepted = charDone & ~rxFifoFull & dmaMode & (dmaActive | dmaStart);

  always_comb begin
    strobes         = '0;
    strobes.setOvr  = charDone & rxFifoFull;
    strobes.clrOvr  = statWrite;
    strobes.loadPio = ~dmaMode & dataRead;
    strobes.accDma  = accepted;
    strobes.dmaClr  = dmaStart;
    strobes.cntInc  = accepted;
    strobes.loadInv = dataRead;
    for (int i = 0; i < NUM_ERR; i++)
      strobes.clrErr[i] = statWrite & ~statWrData[ERR_LSB+i];
  end
endmodule

// File: rtl/uart_rx_status_dp.sv
module uart_rx_status_dp
  import uart_rx_status_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int LANES  = 4,
  parameter int STAT_W = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  rxStrobes_t                 strobes,
  input  logic [NUM_ERR-1:0]         charErr,
  input  logic [NUM_ERR-1:0]         readErr,
  input  logic [$clog2(LANES+1)-1:0] readBytes,
  input  logic                       rxFifoEmpty,
  input  logic                       rxFifoFull,
  input  logic                       txFifoFull,
  output logic [STAT_W-1:0]          status
);
  localparam int RB_W      = $clog2(LANES+1);
  localparam int INV_LSB   = CNT_W;
  localparam int ERR_LSB   = INV_LSB + LANES;
  localparam int OVR_POS   = ERR_LSB + NUM_ERR;
  localparam int EMPTY_POS = OVR_POS + 1;
  localparam int RXF_POS   = OVR_POS + 2;
  localparam int TXF_POS   = OVR_POS + 3;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [NUM_ERR-1:0] errFlag, errNext;
  logic               ovrFlag;
  logic [CNT_W-1:0]   count, countNext;
  logic [LANES-1:0]   invMask;
  logic [RB_W-1:0]    bytesClamped;

  // Error flags: one slice per error kind
  for (genvar g = 0; g < NUM_ERR; g++) begin : gErr
    always_comb begin
      errNext[g] = errFlag[g];
      if (strobes.loadPio) begin
        errNext[g] = readErr[g];
      end else begin
        if (strobes.dmaClr || strobes.clrErr[g]) errNext[g] = 1'b0;
        if (strobes.accDma && charErr[g])        errNext[g] = 1'b1;
      end
    end
    always_ff @(posedge clk) begin
      if (!rstN) errFlag[g] <= 1'b0;
      else       errFlag[g] <= errNext[g];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               ovrFlag <= 1'b0;
    else if (strobes.setOvr) ovrFlag <= 1'b1;
    else if (strobes.clrOvr) ovrFlag <= 1'b0;
  end

  always_comb begin
    countNext = strobes.dmaClr ? '0 : count;
    if (strobes.cntInc && countNext != CNT_MAX) countNext = countNext + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) count <= '0;
    else       count <= countNext;
  end

  assign bytesClamped = (readBytes > RB_W'(LANES)) ? RB_W'(LANES) : readBytes;

  for (genvar l = 0; l < LANES; l++) begin : gLane
    always_ff @(posedge clk) begin
      if (!rstN)                invMask[l] <= 1'b0;
      else if (strobes.loadInv) invMask[l] <= (RB_W'(l) >= bytesClamped);
    end
  end

  always_comb begin
    status                           = '0;
    status[CNT_W-1:0]                = count;
    status[INV_LSB +: LANES]         = invMask;
    status[ERR_LSB +: NUM_ERR]       = errFlag;
    status[OVR_POS]                  = ovrFlag;
    status[EMPTY_POS]                = rxFifoEmpty;
    status[RXF_POS]                  = rxFifoFull;
    status[TXF_POS]                  = txFifoFull;
  end
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_status_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int LANES  = 4,
  parameter int STAT_W = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       dmaMode,
  input  logic                       charDone,
  input  logic [2:0]                 charErr,
  input  logic                       rxFifoFull,
  input  logic                       rxFifoEmpty,
  input  logic                       txFifoFull,
  input  logic                       dataRead,
  input  logic [2:0]                 readErr,
  input  logic [$clog2(LANES+1)-1:0] readBytes,
  input  logic                       dmaStart,
  input  logic                       dmaEnd,
  input  logic                       statWrite,
  input  logic [STAT_W-1:0]          statWrData,
  output logic [STAT_W-1:0]          status
);
  localparam int ERR_LSB = CNT_W + LANES;

  rxStrobes_t strobes;

  uart_rx_status_ctrl #(.ERR_LSB(ERR_LSB), .STAT_W(STAT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .dmaMode(dmaMode), .charDone(charDone),
    .rxFifoFull(rxFifoFull), .dataRead(dataRead), .dmaStart(dmaStart),
    .dmaEnd(dmaEnd), .statWrite(statWrite), .statWrData(statWrData),
    .strobes(strobes)
  );

  uart_rx_status_dp #(.CNT_W(CNT_W), .LANES(LANES), .STAT_W(STAT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .charErr(charErr),
    .readErr(readErr), .readBytes(readBytes), .rxFifoEmpty(rxFifoEmpty),
    .rxFifoFull(rxFifoFull), .txFifoFull(txFifoFull), .status(status)
  );
endmodule

// File: rtl/uart_rx_status_chk.sv
module uart_rx_status_chk (
  input logic        clk,
  input logic        rstN,
  input logic        dmaMode,
  input logic        charDone,
  input logic [2:0]  charErr,
  input logic        rxFifoFull,
  input logic        rxFifoEmpty,
  input logic        txFifoFull,
  input logic        dataRead,
  input logic [2:0]  readErr,
  input logic [2:0]  readBytes,
  input logic        dmaStart,
  input logic        dmaEnd,
  input logic        statWrite,
  input logic [31:0] statWrData,
  input logic [31:0] status
);
  // R1
  level_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    status[26:24] == {txFifoFull, rxFifoFull, rxFifoEmpty} && status[31:27] == 5'd0);

  // R2
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    charDone && rxFifoFull |=> status[23]);

  // R3
  ovr_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    statWrite && !(charDone && rxFifoFull) |=> !status[23]);

  // R4
  pio_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dmaMode && dataRead |=> status[22:20] == $past(readErr));

  // R5
  dma_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    dmaMode && status[22] && !dmaStart && !statWrite |=> status[22]);

  // R6
  zero_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    statWrite && !statWrData[21] && !dataRead && !charDone |=> !status[21]);

  // R7
  cnt_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    dmaStart && !charDone |=> status[15:0] == 16'd0);

  // R8
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    status[15:0] == 16'hFFFF && !dmaStart |=> status[15:0] == 16'hFFFF);

  // R9
  inv_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataRead && readBytes >= 3'd4 |=> status[19:16] == 4'b0000);
endmodule

bind uart_rx_status uart_rx_status_chk chk_i (
  .clk(clk), .rstN(rstN), .dmaMode(dmaMode), .charDone(charDone),
  .charErr(charErr), .rxFifoFull(rxFifoFull), .rxFifoEmpty(rxFifoEmpty),
  .txFifoFull(txFifoFull), .dataRead(dataRead), .readErr(readErr),
  .readBytes(readBytes), .dmaStart(dmaStart), .dmaEnd(dmaEnd),
  .statWrite(statWrite), .statWrData(statWrData), .status(status)
);

// File: tb/uart_rx_status_tb_top.sv
module uart_rx_status_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        dmaMode = 0, charDone = 0, rxFifoFull = 0, rxFifoEmpty = 0, txFifoFull = 0;
  logic        dataRead = 0, dmaStart = 0, dmaEnd = 0, statWrite = 0;
  logic [2:0]  charErr = 0, readErr = 0, readBytes = 0;
  logic [31:0] statWrData = 0;
  logic [31:0] status;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;   // 250 MHz

  uart_rx_status dut_i (
    .clk(clk), .rstN(rstN), .dmaMode(dmaMode), .charDone(charDone), .charErr(charErr),
    .rxFifoFull(rxFifoFull), .rxFifoEmpty(rxFifoEmpty), .txFifoFull(txFifoFull),
    .dataRead(dataRead), .readErr(readErr), .readBytes(readBytes), .dmaStart(dmaStart),
    .dmaEnd(dmaEnd), .statWrite(statWrite), .statWrData(statWrData), .status(status)
  );

  typedef struct packed {
    logic        dma;
    logic        chr;
    logic [2:0]  cerr;
    logic        full;
    logic        rd;
    logic [2:0]  rerr;
    logic [2:0]  rb;
    logic        st;
    logic        en;
    logic        wr;
    logic [3:0]  wb;    // written bits 23..20 {ovr, brk, par, frm}
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{0,0,3'b000,0,1,3'b101,3'd4,0,0,0,4'h0,32'h0050_0000}, // R4 R9 full word
    '{0,0,3'b000,0,1,3'b010,3'd1,0,0,0,4'h0,32'h002E_0000}, // R4 R9 one byte
    '{0,0,3'b000,0,0,3'b000,3'd0,0,0,1,4'hF,32'h002E_0000}, // R6 ones keep
    '{0,0,3'b000,0,0,3'b000,3'd0,0,0,1,4'hD,32'h000E_0000}, // R6 zero clears parity
    '{0,1,3'b000,1,0,3'b000,3'd0,0,0,0,4'h0,32'h028E_0000}, // R2 R1 overrun
    '{0,0,3'b000,0,0,3'b000,3'd0,0,0,1,4'hF,32'h000E_0000}, // R3 any write clears
    '{0,1,3'b000,1,0,3'b000,3'd0,0,0,1,4'hF,32'h028E_0000}, // R2 set beats write
    '{1,1,3'b000,0,0,3'b000,3'd0,1,0,0,4'h0,32'h008E_0001}, // R7 start cycle counts
    '{1,1,3'b100,0,0,3'b000,3'd0,0,0,0,4'h0,32'h00CE_0002}, // R5 break
    '{1,1,3'b001,0,0,3'b000,3'd0,0,0,0,4'h0,32'h00DE_0003}, // R5 sticky plus framing
    '{1,1,3'b010,1,0,3'b000,3'd0,0,0,0,4'h0,32'h02DE_0003}, // R2 R7 overrun not counted
    '{1,1,3'b000,0,0,3'b000,3'd0,0,1,0,4'h0,32'h00DE_0004}, // R7 end cycle counts
    '{1,1,3'b010,0,0,3'b000,3'd0,0,0,0,4'h0,32'h00DE_0004}, // R7 after end ignored
    '{1,0,3'b000,0,1,3'b111,3'd2,0,0,0,4'h0,32'h00DC_0004}, // R5 R9 DMA read no load
    '{1,0,3'b000,0,0,3'b000,3'd0,0,0,1,4'h0,32'h000C_0004}, // R3 R6 zero write
    '{1,0,3'b000,0,0,3'b000,3'd0,1,0,0,4'h0,32'h000C_0000}, // R7 start zeroes
    '{1,1,3'b100,0,0,3'b000,3'd0,0,0,1,4'hB,32'h004C_0001}, // R6 accumulate beats clear
    '{0,0,3'b000,0,1,3'b000,3'd0,0,0,0,4'h0,32'h000F_0001}  // R4 R9 zero-byte read
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    dmaMode = 0; charDone = 0; charErr = 0; rxFifoFull = 0; dataRead = 0; readErr = 0;
    readBytes = 0; dmaStart = 0; dmaEnd = 0; statWrite = 0; statWrData = 0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R10 reset", status, 32'h0);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1 check("R10 after reset", status, 32'h0);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      dmaMode = VECS[v].dma; charDone = VECS[v].chr; charErr = VECS[v].cerr;
      rxFifoFull = VECS[v].full; dataRead = VECS[v].rd; readErr = VECS[v].rerr;
      readBytes = VECS[v].rb; dmaStart = VECS[v].st; dmaEnd = VECS[v].en;
      statWrite = VECS[v].wr; statWrData = {8'h0, VECS[v].wb, 20'h0};
      @(posedge clk); #1 check($sformatf("vector %0d", v), status, VECS[v].exp);
    end

    // R1 combinational pass-through, no clock edge in between
    @(negedge clk); idle();
    rxFifoEmpty = 1; txFifoFull = 1; #0.5;
    check("R1 levels", status, 32'h050F_0001);
    rxFifoEmpty = 0; txFifoFull = 0; #0.5;
    check("R1 levels low", status, 32'h000F_0001);

    // R9 three valid bytes, and an out-of-range count treated as four
    @(negedge clk); dataRead = 1; readBytes = 3'd3;
    @(posedge clk); #1 check("R9 three bytes", status, 32'h0008_0001);
    @(negedge clk); readBytes = 3'd6;
    @(posedge clk); #1 check("R9 clamp", status, 32'h0000_0001);

    // R8 saturation
    @(negedge clk); idle(); dmaMode = 1; dmaStart = 1; charDone = 1;
    @(negedge clk); dmaStart = 0;
    repeat (65534) @(negedge clk);
    #1 check("R8 reach max", status, 32'h0000_FFFF);
    @(posedge clk); #1 check("R8 saturate", status, 32'h0000_FFFF);

    // R10 reset after activity
    @(negedge clk); idle(); statWrite = 1; statWrData = 32'h0;
    charDone = 1; rxFifoFull = 1;
    @(negedge clk); idle(); rstN = 0;
    @(posedge clk); #1 check("R10 mid-run reset", status, 32'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule